// File: doc/BRIEF.md
# JTAG-Triggered Debug Interrupt Register

This block lets a debug host on a JTAG port raise an interrupt to an on-chip CPU. It has a sixteen-state TAP controller clocked by TCK, an 8-bit instruction register and a single interrupt-request flag. The flag sets when the host finishes loading the interrupt instruction. The CPU sees the flag as a 16-bit bus register. A CPU write clears the flag only when bit 0 of the write data is 0. The block drives `irq` high for as long as the flag holds 1.

While the interrupt instruction is loaded, the JTAG data path is a 32-bit scan register that shows the same flag, with zero padding above it. Every other instruction code selects a one-bit bypass register. The flag lives in the CPU clock domain. The set and Test-Logic-Reset events cross from the TCK domain through two-flop synchronizers, with an edge detector on the set path, so each Update-IR produces one set pulse. The flag crosses the other way through a two-flop synchronizer before it is captured into the scan register. TCK must be slower than the CPU clock, and a TCK period must cover at least three CPU clock cycles.

Top module: `jtag_dbg_irq`

## Requirements
- R1: The TAP follows the standard sixteen-state JTAG sequence. Five consecutive TCK edges with TMS=1 reach Test-Logic-Reset from any state. Entering that state clears the flag and reloads the instruction register with all ones, which selects bypass.
- R2: The instruction register is 8 bits wide and is shifted LSB first. Capture-IR loads 8'h01, so the first eight TDO bits of an IR scan read 1,0,0,0,0,0,0,0.
- R3: An Update-IR that loads the code INT_CODE (default 8'h20) sets the flag on the third CPU clock edge after the TCK edge that enters Update-IR.
- R4: Each Update-IR with INT_CODE sets the flag once only. After the CPU clears the flag, it stays 0 while the instruction stays loaded, including across DR scans.
- R5: With INT_CODE loaded, Capture-DR loads a 32-bit word. Bit 0 is the flag and bits 31..1 are 0. Shift-DR presents the word on TDO LSB first.
- R6: Update-DR does not change the flag, whatever was shifted in.
- R7: Any other instruction code selects a one-bit bypass register. Capture-DR loads 0 into it, and in Shift-DR, TDO repeats TDI one TCK later.
- R8: A read with `bus_rd`=1 at address REG_ADDR (default 4'h6) returns {15'b0, flag}. Any other address reads 0.
- R9: A write at REG_ADDR with `bus_wdata[0]`=0 clears the flag at that clock edge. A write with bit 0 at 1 leaves the flag unchanged. Bits 15..1 are ignored, and writes to other addresses have no effect.
- R10: When a set pulse and a CPU clearing write fall on the same clock edge, the flag becomes 1.
- R11: `irq` equals the flag on every cycle.
- R12: Driving `trst_n` low clears the flag on the third CPU clock edge after the assertion and forces the TAP into Test-Logic-Reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | CPU-domain asynchronous active-low reset |
| bus_addr | input | 4 | CPU register address |
| bus_rd | input | 1 | CPU read strobe |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | 16 | CPU write data |
| bus_rdata | output | 16 | CPU read data (0 when not selected) |
| irq | output | 1 | Level interrupt request to the CPU |
| tck | input | 1 | JTAG test clock |
| trst_n | input | 1 | JTAG asynchronous active-low test reset |
| tms | input | 1 | JTAG mode select |
| tdi | input | 1 | JTAG serial data in |
| tdo | output | 1 | JTAG serial data out (0 outside shift states) |

## Verification
The irq and read-data outputs show a wrong flag state on the first clock edge, because both are driven directly from the flag register. The bench's cycle model predicts `irq` on every CPU cycle, so a set or clear that is late, early, missing or doubled shows up within one cycle of the expected edge. A wrong TAP state or a wrong instruction has no direct output. It shows up only at the next scan, as the wrong TDO stream (capture pattern, bypass delay or 32-bit word), or as a missing `irq` three cycles after Update-IR.

// File: rtl/jdi_pkg.sv
package jdi_pkg;
  typedef enum logic [3:0] {
    TAP_RESET, TAP_IDLE,
    TAP_SEL_DR, TAP_CAP_DR, TAP_SHF_DR, TAP_EX1_DR, TAP_PAU_DR, TAP_EX2_DR, TAP_UPD_DR,
    TAP_SEL_IR, TAP_CAP_IR, TAP_SHF_IR, TAP_EX1_IR, TAP_PAU_IR, TAP_EX2_IR, TAP_UPD_IR
  } tap_state_e;

  localparam int unsigned IR_W = 8;
  localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;
endpackage

// File: rtl/jdi_sync.sv
module jdi_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/jdi_tap.sv
module jdi_tap
  import jdi_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state_q,
  output tap_state_e state_nx
);
  always_comb begin
    state_nx = state_q;
    case (state_q)
      TAP_RESET:  state_nx = tms ? TAP_RESET  : TAP_IDLE;
      TAP_IDLE:   state_nx = tms ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_DR: state_nx = tms ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR: state_nx = tms ? TAP_EX1_DR : TAP_SHF_DR;
      TAP_SHF_DR: state_nx = tms ? TAP_EX1_DR : TAP_SHF_DR;
      TAP_EX1_DR: state_nx = tms ? TAP_UPD_DR : TAP_PAU_DR;
      TAP_PAU_DR: state_nx = tms ? TAP_EX2_DR : TAP_PAU_DR;
      TAP_EX2_DR: state_nx = tms ? TAP_UPD_DR : TAP_SHF_DR;
      TAP_UPD_DR: state_nx = tms ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_IR: state_nx = tms ? TAP_RESET  : TAP_CAP_IR;
      TAP_CAP_IR: state_nx = tms ? TAP_EX1_IR : TAP_SHF_IR;
      TAP_SHF_IR: state_nx = tms ? TAP_EX1_IR : TAP_SHF_IR;
      TAP_EX1_IR: state_nx = tms ? TAP_UPD_IR : TAP_PAU_IR;
      TAP_PAU_IR: state_nx = tms ? TAP_EX2_IR : TAP_PAU_IR;
      TAP_EX2_IR: state_nx = tms ? TAP_UPD_IR : TAP_SHF_IR;
      TAP_UPD_IR: state_nx = tms ? TAP_SEL_DR : TAP_IDLE;
      default:    state_nx = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= TAP_RESET;
    else         state_q <= state_nx;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)
    |=> state_q == TAP_RESET); // R1
endmodule

// File: rtl/jdi_scan.sv
module jdi_scan
  import jdi_pkg::*;
#(
  parameter logic [IR_W-1:0] INT_CODE = 8'h20,
  parameter int unsigned     REG_W    = 16,
  parameter int unsigned     DR_W     = 32
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_e state_q,
  input  tap_state_e state_nx,
  input  logic       flag_cpu,
  output logic       tdo,
  output logic       set_lvl,
  output logic       tlr_lvl
);
  localparam int unsigned PAD_W = DR_W - REG_W;

  logic [IR_W-1:0] ir_sh_q, ir_sh_d, ir_q, ir_d;
  logic [DR_W-1:0] dr_q, dr_d;
  logic            byp_q, byp_d;
  logic            set_d, tlr_d;
  logic            flag_t;
  logic            int_sel;
  logic [REG_W-1:0] reg_view;

  jdi_sync #(.STAGES(2), .RST_VAL(1'b0)) u_flag_sync (
    .clk(tck), .rst_n(trst_n), .d(flag_cpu), .q(flag_t)
  );

  assign int_sel  = (ir_q == INT_CODE);
  assign reg_view = {{(REG_W-1){1'b0}}, flag_t};

  always_comb begin
    ir_sh_d = ir_sh_q;
    ir_d    = ir_q;
    dr_d    = dr_q;
    byp_d   = byp_q;
    case (state_q)
      TAP_RESET:  ir_d    = '1;
      TAP_CAP_IR: ir_sh_d = IR_CAPTURE;
      TAP_SHF_IR: ir_sh_d = {tdi, ir_sh_q[IR_W-1:1]};
      TAP_UPD_IR: ir_d    = ir_sh_q;
      TAP_CAP_DR: begin
        if (int_sel) dr_d  = {{PAD_W{1'b0}}, reg_view};
        else         byp_d = 1'b0;
      end
      TAP_SHF_DR: begin
        if (int_sel) dr_d  = {tdi, dr_q[DR_W-1:1]};
        else         byp_d = tdi;
      end
      default: ;
    endcase
    set_d = (state_nx == TAP_UPD_IR) && (ir_sh_q == INT_CODE);
    tlr_d = (state_nx == TAP_RESET);
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh_q <= '0;
      ir_q    <= '1;
      dr_q    <= '0;
      byp_q   <= 1'b0;
      set_lvl <= 1'b0;
      tlr_lvl <= 1'b1;
    end else begin
      ir_sh_q <= ir_sh_d;
      ir_q    <= ir_d;
      dr_q    <= dr_d;
      byp_q   <= byp_d;
      set_lvl <= set_d;
      tlr_lvl <= tlr_d;
    end
  end

  always_comb begin
    tdo = 1'b0;
    if (state_q == TAP_SHF_IR)      tdo = ir_sh_q[0];
    else if (state_q == TAP_SHF_DR) tdo = int_sel ? dr_q[0] : byp_q;
  end

  AST_SET_ONLY_IN_UPDATE_IR: assert property (@(posedge tck) disable iff (!trst_n)
    set_lvl |-> state_q == TAP_UPD_IR); // R3
  AST_BYPASS_ONE_STAGE: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == TAP_SHF_DR) && (ir_q != INT_CODE) |=> byp_q == $past(tdi)); // R7
  AST_TLR_LOADS_BYPASS: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == TAP_RESET) |=> ir_q != INT_CODE); // R1
endmodule

// File: rtl/jdi_cpu_reg.sv
module jdi_cpu_reg #(
  parameter int unsigned       ADDR_W   = 4,
  parameter int unsigned       REG_W    = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_lvl,
  input  logic              tlr_lvl,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              flag_q
);
  logic set_s, tlr_s, set_d3_q;
  logic set_pulse, hit, wr_clr, flag_d;
  logic wdata_unused;

  jdi_sync #(.STAGES(2), .RST_VAL(1'b0)) u_set_sync (
    .clk(clk), .rst_n(rst_n), .d(set_lvl), .q(set_s)
  );
  jdi_sync #(.STAGES(2), .RST_VAL(1'b1)) u_tlr_sync (
    .clk(clk), .rst_n(rst_n), .d(tlr_lvl), .q(tlr_s)
  );

  assign wdata_unused = ^bus_wdata[REG_W-1:1];
  assign set_pulse    = set_s & ~set_d3_q;
  assign hit          = (bus_addr == REG_ADDR);
  assign wr_clr       = bus_wr & hit & ~bus_wdata[0];

  always_comb begin
    flag_d = flag_q;
    if (tlr_s)          flag_d = 1'b0;
    else if (set_pulse) flag_d = 1'b1;
    else if (wr_clr)    flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      set_d3_q <= 1'b0;
    end else begin
      flag_q   <= flag_d;
      set_d3_q <= set_s;
    end
  end

  assign bus_rdata = (bus_rd && hit) ? {{(REG_W-1){1'b0}}, flag_q} : '0;

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse && !tlr_s |=> flag_q); // R10
  AST_SINGLE_SET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> !set_pulse); // R4
  AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && hit && bus_wdata[0] && !set_pulse && !tlr_s |=> $stable(flag_q)); // R9
  AST_WRITE_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && !set_pulse && !tlr_s |=> !flag_q); // R9
  AST_TLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tlr_s |=> !flag_q); // R12
endmodule

// File: rtl/jtag_dbg_irq.sv
module jtag_dbg_irq
  import jdi_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h6,
  parameter logic [IR_W-1:0]   INT_CODE = 8'h20,
  parameter int unsigned       REG_W    = 16,
  parameter int unsigned       DR_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq,
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo
);
  tap_state_e state_q, state_nx;
  logic       set_lvl, tlr_lvl, flag_q;

  jdi_tap u_tap (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state_q(state_q), .state_nx(state_nx)
  );

  jdi_scan #(.INT_CODE(INT_CODE), .REG_W(REG_W), .DR_W(DR_W)) u_scan (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state_q(state_q), .state_nx(state_nx),
    .flag_cpu(flag_q), .tdo(tdo), .set_lvl(set_lvl), .tlr_lvl(tlr_lvl)
  );

  jdi_cpu_reg #(.ADDR_W(ADDR_W), .REG_W(REG_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .set_lvl(set_lvl), .tlr_lvl(tlr_lvl),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .flag_q(flag_q)
  );

  assign irq = flag_q;
endmodule

// File: tb/jtag_dbg_irq_test.sv
module jtag_dbg_irq_test;
  localparam logic [3:0] RA  = 4'h6;
  localparam logic [7:0] INT = 8'h20;
  localparam int T_RST = 0, T_IDLE = 1, T_SDR = 2, T_CDR = 3, T_SHDR = 4, T_X1DR = 5,
                 T_PDR = 6, T_X2DR = 7, T_UDR = 8, T_SIR = 9, T_CIR = 10, T_SHIR = 11,
                 T_X1IR = 12, T_PIR = 13, T_X2IR = 14, T_UIR = 15;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, trst_n, tck, tms, tdi, bus_rd, bus_wr;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        irq, tdo;

  jtag_dbg_irq uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  int         m_st = T_RST;
  logic [7:0] m_irsh = 8'h00;
  bit         m_flag = 0;
  int         set_cnt = 0, clr_cnt = 0;
  bit         mon_en = 0;
  bit         cnt_en = 0;
  int         hi_cnt = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int tap_next(input int s, input bit m);
    case (s)
      T_RST:  return m ? T_RST  : T_IDLE;
      T_IDLE: return m ? T_SDR  : T_IDLE;
      T_SDR:  return m ? T_SIR  : T_CDR;
      T_CDR:  return m ? T_X1DR : T_SHDR;
      T_SHDR: return m ? T_X1DR : T_SHDR;
      T_X1DR: return m ? T_UDR  : T_PDR;
      T_PDR:  return m ? T_X2DR : T_PDR;
      T_X2DR: return m ? T_UDR  : T_SHDR;
      T_UDR:  return m ? T_SDR  : T_IDLE;
      T_SIR:  return m ? T_RST  : T_CIR;
      T_CIR:  return m ? T_X1IR : T_SHIR;
      T_SHIR: return m ? T_X1IR : T_SHIR;
      T_X1IR: return m ? T_UIR  : T_PIR;
      T_PIR:  return m ? T_X2IR : T_PIR;
      T_X2IR: return m ? T_UIR  : T_SHIR;
      default: return m ? T_SDR : T_IDLE;
    endcase
  endfunction

  // cycle model of the flag: events land on the third clk edge (R3, R12), set beats clear (R10)
  always @(posedge clk) begin
    bit fire_set, fire_clr;
    fire_set = (set_cnt == 1);
    fire_clr = (clr_cnt == 1);
    if (set_cnt > 0) set_cnt--;
    if (clr_cnt > 0) clr_cnt--;
    if (fire_clr)      m_flag = 0;
    else if (fire_set) m_flag = 1;
    else if (bus_wr && bus_addr == RA && !bus_wdata[0]) m_flag = 0;
  end

  // R11: irq compared with the model on every clock
  always @(negedge clk) begin
    if (mon_en) check(irq === m_flag, "R11 irq vs model", irq, m_flag);
    if (cnt_en && irq) hi_cnt++;
  end

  task automatic tck_cycle(input bit t_ms, input bit t_di, output bit t_do);
    int nx;
    @(negedge clk); tms = t_ms; tdi = t_di;
    @(negedge clk); t_do = tdo;
    nx = tap_next(m_st, t_ms);
    if (m_st == T_CIR)       m_irsh = 8'h01;
    else if (m_st == T_SHIR) m_irsh = {t_di, m_irsh[7:1]};
    if (nx == T_UIR && m_irsh == INT) set_cnt = 3;
    if (nx == T_RST && m_st != T_RST) clr_cnt = 3;
    m_st = nx;
    tck = 1'b1;
    repeat (4) @(negedge clk);
    tck = 1'b0;
  endtask

  task automatic scan_ir(input logic [7:0] code, output logic [7:0] cap);
    bit o;
    tck_cycle(1, 0, o); tck_cycle(1, 0, o); tck_cycle(0, 0, o); tck_cycle(0, 0, o);
    for (int i = 0; i < 8; i++) begin
      tck_cycle(i == 7, code[i], o);
      cap[i] = o;
    end
    tck_cycle(1, 0, o); tck_cycle(0, 0, o);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    bit o;
    dout = '0;
    tck_cycle(1, 0, o); tck_cycle(0, 0, o); tck_cycle(0, 0, o);
    for (int i = 0; i < n; i++) begin
      tck_cycle(i == n - 1, din[i], o);
      dout[i] = o;
    end
    tck_cycle(1, 0, o); tck_cycle(0, 0, o);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0]  cap;
    logic [31:0] dout;
    logic [15:0] rd;
    bit          o;
    rst_n = 0; trst_n = 0; tck = 0; tms = 1; tdi = 0;
    bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    wait_clk(4);
    rst_n = 1; trst_n = 1;
    wait_clk(4);
    mon_en = 1;
    check(irq == 0, "R11 reset irq", irq, 0);
    check(tdo == 0, "R1 reset tdo", tdo, 0);
    bus_read(RA, rd);
    check(rd == 16'h0000, "R8 reset read", rd, 0);

    // five ones then idle
    for (int i = 0; i < 5; i++) tck_cycle(1, 0, o);
    tck_cycle(0, 0, o);

    // R2 capture pattern, R3 set
    scan_ir(INT, cap);
    check(cap == 8'h01, "R2 IR capture", cap, 8'h01);
    wait_clk(6);
    check(irq == 1, "R3 flag set by Update-IR", irq, 1);
    bus_read(RA, rd);
    check(rd == 16'h0001, "R8 read flag", rd, 16'h0001);
    bus_read(4'h2, rd);
    check(rd == 16'h0000, "R8 other address", rd, 0);

    // R5 scan word, R6 update keeps flag
    scan_dr(32, 32'hFFFF_FFFF, dout);
    check(dout == 32'h0000_0001, "R5 scan word flag=1", dout, 32'h1);
    wait_clk(6);
    check(irq == 1, "R6 Update-DR keeps flag", irq, 1);
    scan_dr(32, 32'h0000_0000, dout);
    wait_clk(6);
    check(irq == 1, "R6 zeros shifted keep flag", irq, 1);

    // R9 write semantics
    bus_write(RA, 16'hFFFF);
    wait_clk(2);
    check(irq == 1, "R9 write 1 keeps", irq, 1);
    bus_write(4'h2, 16'h0000);
    wait_clk(2);
    check(irq == 1, "R9 other address write ignored", irq, 1);
    bus_write(RA, 16'hFFFE);
    wait_clk(1);
    check(irq == 0, "R9 write 0 clears", irq, 0);

    // R4 no re-set while instruction remains
    wait_clk(30);
    check(irq == 0, "R4 no second set", irq, 0);
    scan_dr(32, 32'h0000_0001, dout);
    check(dout == 32'h0, "R5 scan word flag=0", dout, 0);
    wait_clk(6);
    check(irq == 0, "R4 DR scan does not set", irq, 0);

    // R10 set wins over simultaneous clear
    @(negedge clk); bus_addr = RA; bus_wdata = 16'h0000; bus_wr = 1'b1;
    hi_cnt = 0; cnt_en = 1;
    scan_ir(INT, cap);
    wait_clk(10);
    cnt_en = 0; bus_wr = 1'b0;
    check(hi_cnt == 1, "R10 set beats clear", hi_cnt, 1);

    // R7 bypass for other codes
    scan_ir(8'h21, cap);
    scan_dr(8, 32'h0000_00B2, dout);
    check(dout[7:0] == 8'h64, "R7 bypass delay", dout[7:0], 8'h64);
    scan_ir(8'hFF, cap);
    scan_dr(8, 32'h0000_004D, dout);
    check(dout[7:0] == 8'h9A, "R7 bypass all-ones code", dout[7:0], 8'h9A);

    // R1 five TMS=1 from Shift-DR clears flag and selects bypass
    scan_ir(INT, cap);
    wait_clk(6);
    check(irq == 1, "R3 set again", irq, 1);
    tck_cycle(1, 0, o); tck_cycle(0, 0, o); tck_cycle(0, 0, o);
    for (int i = 0; i < 5; i++) tck_cycle(1, 0, o);
    wait_clk(6);
    check(irq == 0, "R1 TLR clears flag", irq, 0);
    tck_cycle(0, 0, o);
    scan_dr(4, 32'h0000_0005, dout);
    check(dout[3:0] == 4'hA, "R1 TLR selects bypass", dout[3:0], 4'hA);

    // R12 TRST
    scan_ir(INT, cap);
    wait_clk(6);
    check(irq == 1, "R3 set before TRST", irq, 1);
    @(negedge clk); trst_n = 0; clr_cnt = 3; m_st = T_RST;
    wait_clk(6);
    check(irq == 0, "R12 TRST clears flag", irq, 0);
    trst_n = 1;
    tck_cycle(0, 0, o);
    scan_dr(4, 32'h0000_0003, dout);
    check(dout[3:0] == 4'h6, "R12 TRST forces bypass", dout[3:0], 4'h6);
    wait_clk(4);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule